// File: doc/BRIEF.md
# Global Exclusive Reservation Monitor

This block is the shared half of an exclusive-access scheme for a cluster of cores. It holds one reservation entry for each core. An entry carries an Open or Exclusive state, the address that was tagged, and a small counter that drives failure injection. Each core's load/store path sends it one notification per cycle. A notification is an exclusive load, an ordinary store, an exclusive store or a removal request. Each one carries the core number and a 32-bit address. Requests reach the block already serialised, so no two arrive in the same cycle.

An exclusive load tags the core's entry and enrols the core as a participant. An ordinary store from any core drops every live reservation. An exclusive store passes only if the requester holds an exclusive reservation on exactly that address. A pass also knocks out the reservations of other cores that sit in the same granule. Every few exact matches, a core's store fails on purpose, so that software retry loops get exercised. A paired ordinary store is sent as two separate store notifications. The core combines the verdict with its local monitor. Memory is written only when both pass, and the status register receives 0 on success and 1 on failure.

Top module: `excl_global_monitor`

## Requirements
- R1: After reset every entry is Open, every failure counter is 0, no core is enrolled, and `rsp_valid` is low, so an exclusive store issued straight after reset fails.
- R2: For every cycle with `req_valid` high, `rsp_valid` is high in the next cycle and only then. `rsp_pass` is high only in the cycle after an exclusive store that passes. The op codes are: 0 exclusive load, 1 ordinary store, 2 exclusive store, 3 remove core.
- R3: An exclusive load followed by an exclusive store from the same core to the identical address passes, and the pass leaves that core's entry Open.
- R4: An exclusive store fails when the requester's entry is Open, or when the address differs from the tag in any bit, including bits inside the granule.
- R5: An ordinary store from any core, to any address, returns every enrolled Exclusive entry to Open, including the storing core's own entry.
- R6: Each core counts its exact-match exclusive stores. With the default limit of 5, the match that finds the counter at 5 fails, resets the counter to 0 and opens the entry. Such an injected failure leaves other cores' entries untouched. Counters are per core.
- R7: A passing exclusive store opens every other core's Exclusive entry whose tag matches the store address once the 3 low bits are masked (8-byte granule). Entries outside that granule stay Exclusive.
- R8: An exclusive store that fails because its address mismatches changes no entry. This includes the requester's own entry, which can still pass later at its tagged address.
- R9: A removed core is ignored by all notifications, and its exclusive stores fail, until it issues another exclusive load. That load enrols it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Notification present this cycle |
| req_core | input | $clog2(NCORES) | Requesting core number |
| req_op | input | 2 | 0 exclusive load, 1 store, 2 exclusive store, 3 remove |
| req_addr | input | AW | Access address |
| rsp_valid | output | 1 | High in the cycle after each request |
| rsp_pass | output | 1 | Exclusive store verdict: 1 pass, 0 fail |

## Verification
The bench targets the points where exact and masked matching meet. A same-granule but different-address store must fail for its requester (R4), yet a pass must still open a neighbour whose tag lies in the same granule (R7). A design that masks the requester's compare would pass the first case, and one that compares the neighbour exactly would leave a stale reservation alive. The sixth consecutive match per core must fail and leave another core's reservation on the same address intact. An off-by-one counter or an injected failure that broadcasts would show up there. The bench also checks that a mismatched store keeps its requester's reservation alive, and that a removed core's store fails until its next exclusive load.

// File: rtl/excl_global_monitor.sv
module excl_global_monitor #(
  parameter int NCORES   = 4,
  parameter int AW       = 32,
  parameter int MAX_FAIL = 5,
  parameter logic [AW-1:0] GRAN_MASK = {{(AW-3){1'b1}}, 3'b000}
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [(NCORES>1?$clog2(NCORES):1)-1:0] req_core,
  input  logic [1:0]                            req_op,
  input  logic [AW-1:0]                         req_addr,
  output logic                                  rsp_valid,
  output logic                                  rsp_pass
);
  localparam int CW = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam int FW = $clog2(MAX_FAIL + 1);
  localparam logic [FW-1:0] FAIL_LIM = FW'(MAX_FAIL);
  localparam logic [1:0] OP_LDX = 2'd0;
  localparam logic [1:0] OP_ST  = 2'd1;
  localparam logic [1:0] OP_STX = 2'd2;
  localparam logic [1:0] OP_REM = 2'd3;

  logic [NCORES-1:0] excl_q, enrl_q;
  logic [AW-1:0]     tag_q [NCORES];
  logic [FW-1:0]     cnt_q [NCORES];

  logic core_ok, own_live, hit, inject, pass;
  assign core_ok  = 32'(req_core) < NCORES;
  assign own_live = core_ok && excl_q[req_core] && enrl_q[req_core];
  assign hit      = req_valid && req_op == OP_STX && own_live && tag_q[req_core] == req_addr;
  assign inject   = hit && cnt_q[req_core] >= FAIL_LIM;
  assign pass     = hit && !inject;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excl_q    <= '0;
      enrl_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_pass  <= 1'b0;
      for (int i = 0; i < NCORES; i++) begin
        tag_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      rsp_valid <= req_valid;
      rsp_pass  <= pass;
      if (req_valid) begin
        for (int i = 0; i < NCORES; i++) begin
          if (req_op == OP_LDX && core_ok && req_core == CW'(i)) begin
            excl_q[i] <= 1'b1;
            enrl_q[i] <= 1'b1;
            tag_q[i]  <= req_addr;
          end else if (req_op == OP_ST && enrl_q[i]) begin
            excl_q[i] <= 1'b0;
          end else if (req_op == OP_STX) begin
            if (hit && req_core == CW'(i)) begin
              excl_q[i] <= 1'b0;
              cnt_q[i]  <= inject ? '0 : cnt_q[i] + 1'b1;
            end else if (pass && req_core != CW'(i) && enrl_q[i] && excl_q[i] &&
                         (tag_q[i] & GRAN_MASK) == (req_addr & GRAN_MASK)) begin
              excl_q[i] <= 1'b0;
            end
          end else if (req_op == OP_REM && core_ok && req_core == CW'(i)) begin
            enrl_q[i] <= 1'b0;
          end
        end
      end
    end
  end

  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r2_rsp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_pass_only_stx: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pass |-> rsp_valid && $past(req_op) == OP_STX);
  a_r3_pass_opens_own: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pass |-> !excl_q[$past(req_core)]);
  a_r5_store_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_ST) |=> (excl_q & enrl_q) == '0);
  a_r9_removed_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_STX && core_ok && !enrl_q[req_core]) |=> !rsp_pass);

  for (genvar g = 0; g < NCORES; g++) begin : g_chk
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[g] <= FAIL_LIM);
  end
endmodule

// File: tb/excl_global_monitor_bench.sv
module excl_global_monitor_bench;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [1:0] req_core = '0, req_op = '0;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_pass;
  int n_chk = 0, n_bad = 0;
  logic got_v, got_p;
  bit done = 0;

  always #5 clk = ~clk;

  excl_global_monitor u_excl_global_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .req_op(req_op), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_pass(rsp_pass));

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic send(input int core, input int op, input logic [31:0] addr);
    @(negedge clk);
    req_valid = 1'b1; req_core = core[1:0]; req_op = op[1:0]; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    got_v = rsp_valid; got_p = rsp_pass;
  endtask

  task automatic stx(input int core, input logic [31:0] addr, input logic exp, input string tag);
    send(core, 2, addr);
    check(tag, got_p, exp);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rsp_valid idle", rsp_valid, 1'b0);
    stx(0, 32'h100, 1'b0, "R1 stx after reset");
    check("R2 valid after stx", got_v, 1'b1);
  endtask

  task automatic t_basic();
    do_reset();
    send(0, 0, 32'h100);
    check("R2 valid after ldx", got_v, 1'b1);
    check("R2 no pass on ldx", got_p, 1'b0);
    @(negedge clk);
    check("R2 valid drops", rsp_valid, 1'b0);
    stx(0, 32'h100, 1'b1, "R3 matched stx");
    stx(0, 32'h100, 1'b0, "R4 entry opened");
  endtask

  task automatic t_mismatch();
    do_reset();
    send(1, 0, 32'h200);
    stx(1, 32'h204, 1'b0, "R4 same granule diff addr");
    stx(1, 32'h200, 1'b1, "R8 own entry kept");
    send(0, 0, 32'h900);
    send(1, 0, 32'h900);
    stx(0, 32'h908, 1'b0, "R8 mismatch fails");
    stx(1, 32'h900, 1'b1, "R8 other entry kept");
    stx(0, 32'h900, 1'b0, "R7 cleared by neighbour pass");
  endtask

  task automatic t_store_clear();
    do_reset();
    send(0, 0, 32'h300);
    send(1, 0, 32'h400);
    send(2, 1, 32'h999);
    check("R2 no pass on store", got_p, 1'b0);
    stx(0, 32'h300, 1'b0, "R5 store clears core0");
    stx(1, 32'h400, 1'b0, "R5 store clears core1");
    send(3, 0, 32'h500);
    send(3, 1, 32'h10);
    stx(3, 32'h500, 1'b0, "R5 own store clears");
  endtask

  task automatic t_granule();
    do_reset();
    send(0, 0, 32'h600);
    send(1, 0, 32'h604);
    send(2, 0, 32'h608);
    stx(0, 32'h600, 1'b1, "R7 requester passes");
    stx(1, 32'h604, 1'b0, "R7 same granule cleared");
    stx(2, 32'h608, 1'b1, "R7 other granule kept");
  endtask

  task automatic t_inject();
    do_reset();
    for (int k = 0; k < 5; k++) begin
      send(0, 0, 32'h700);
      stx(0, 32'h700, 1'b1, "R6 pass before limit");
    end
    send(1, 0, 32'h1000);
    stx(1, 32'h1000, 1'b1, "R6 per-core counter");
    send(0, 0, 32'h700);
    send(1, 0, 32'h700);
    stx(0, 32'h700, 1'b0, "R6 injected failure");
    stx(0, 32'h700, 1'b0, "R6 injected failure opens entry");
    stx(1, 32'h700, 1'b1, "R6 injection keeps others");
    send(0, 0, 32'h700);
    stx(0, 32'h700, 1'b1, "R6 counter restarted");
  endtask

  task automatic t_remove();
    do_reset();
    send(2, 0, 32'h800);
    send(2, 3, 32'h0);
    check("R2 no pass on remove", got_p, 1'b0);
    stx(2, 32'h800, 1'b0, "R9 removed core fails");
    send(2, 0, 32'h800);
    stx(2, 32'h800, 1'b1, "R9 re-enrolled passes");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_mismatch();
    t_store_clear();
    t_granule();
    t_inject();
    t_remove();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule